// File: doc/BRIEF.md
# Operation Lifecycle Controller for an Arithmetic Unit

This block sits between an instruction issue point and a small arithmetic unit. It follows each operation from the cycle it is issued to the cycle its result is taken away. An issue strobe comes with an operation record: an opcode, an invert flag and a force-to-zero flag for the first operand, and an immediate value with its own valid flag. The controller latches that record. For each source operand that it still needs, it raises a release request. It waits for the matching one-cycle go strobe and captures the operand data in that cycle. The two operands are independent and may complete in any order, after any stall, or together.

When every required operand is present, the controller passes the prepared operands to an internal single-stage arithmetic unit over a valid/ready link. It then raises a write release with the result and holds that result until a one-cycle write-go accepts it. Busy covers the whole span from the cycle after issue to the cycle after the write is accepted. Scheduling logic outside the block uses busy to know the unit is occupied. An operand slot is skipped when its read-mask bit is set, when the first operand is forced to zero, or when a valid immediate replaces the second operand.

Top module: `opunit_ctrl`

## Requirements
- R1: After reset, busy is low. Busy rises in the cycle after an accepted issue strobe and never rises without one.
- R2: The opcode, flags, immediate and read-mask are captured in the issue cycle. Changing or clearing them afterwards does not alter the operation.
- R3: The release of each required operand goes high in the cycle after issue and stays high through any number of stall cycles until that operand's go arrives.
- R4: A go asserted in the same cycle its release is first high is accepted. Operand data is taken only in the go cycle; values on the data input in other cycles have no effect.
- R5: An operand's release falls in the cycle after its go and does not rise again within the same operation.
- R6: No release is raised for an operand whose read-mask bit is set (bit 0 is operand A, bit 1 is operand B). None is raised for operand A when zero-A is set, or for operand B when the immediate-valid flag is set. A skipped operand B with no valid immediate takes the value 0, and a skipped operand A takes the value 0.
- R7: With zero-A set, operand A is 0 before inversion. With invert-A set, operand A is bitwise inverted before the arithmetic unit. For example, with 16 bits, inverted 5 plus 2 gives 65532, and inverted zero plus 1 gives 0.
- R8: The write release rises once the result is ready, and the result is held unchanged until a one-cycle write-go. Busy and the write release are low in the following cycle.
- R9: Operands may arrive in either order or together. Each operation performs exactly one transfer on every required operand port and exactly one result transfer.
- R10: An issue strobe while busy is high is ignored. The running operation completes with its original record.
- R11: Reset clears busy, every read release and the write release, and abandons any operation in flight.
- R12: The opcode encodes 0 as A plus B, 1 as A minus B, 2 as bitwise AND and 3 as bitwise XOR, all modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue strobe for a new operation |
| op_code_i | input | 2 | Opcode (see R12) |
| inv_a_i | input | 1 | Invert operand A |
| zero_a_i | input | 1 | Force operand A to zero; no read for A |
| imm_i | input | DW | Immediate value for operand B |
| imm_ok_i | input | 1 | Immediate is valid; no read for B |
| rd_mask_i | input | 2 | Per-operand read skip, bit 0 = A, bit 1 = B |
| rd_go_i | input | 2 | Per-operand go strobe, bit 0 = A, bit 1 = B |
| src_a_i | input | DW | Operand A data, valid only with its go |
| src_b_i | input | DW | Operand B data, valid only with its go |
| wr_go_i | input | 1 | Result accepted strobe |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | 2 | Per-operand release request, bit 0 = A, bit 1 = B |
| wr_rel_o | output | 1 | Result available request |
| result_o | output | DW | Result data, held while the write release is high |

## Verification
Operations run with both operands delivered in the same cycle that their releases rise, and then with A first, B first and both together after stalls. These runs separate correct order-independent collection from a design that assumes a fixed order or an immediate response. Masked, zero-A and immediate cases, including one where no operand is read at all, show whether the skip rules and operand substitution are kept apart. Garbage on the data inputs outside go cycles, an issue poked while busy and a reset mid-operation show that capture happens only at the handshake, that the latched record is kept and that reset abandons cleanly. The write-go is also delayed, to show that the result is held.

// File: rtl/opunit_pkg.sv
package opunit_pkg;

    localparam int NOPS  = 2;
    localparam int SRC_A = 0;
    localparam int SRC_B = 1;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;

    typedef struct packed {
        alu_op_e code;
        logic    inv_a;
        logic    zero_a;
        logic    imm_ok;
    } op_ctl_t;

    // Which operand slots must be fetched through the release/go handshake.
    function automatic logic [NOPS-1:0] operand_need(
        input logic [NOPS-1:0] mask,
        input logic            zero_a,
        input logic            imm_ok
    );
        logic [NOPS-1:0] n;
        n[SRC_A] = ~mask[SRC_A] & ~zero_a;
        n[SRC_B] = ~mask[SRC_B] & ~imm_ok;
        return n;
    endfunction

endpackage

// File: rtl/opunit_slot.sv
module opunit_slot #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          need_i,
    input  logic          busy_i,
    input  logic          go_i,
    input  logic [DW-1:0] data_i,
    output logic          rel_o,
    output logic          have_o,
    output logic [DW-1:0] data_o
);
    logic          need_q;
    logic          got_q;
    logic [DW-1:0] data_q;

    assign rel_o  = busy_i && need_q && !got_q;
    assign have_o = !need_q || got_q;
    assign data_o = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            need_q <= 1'b0;
            got_q  <= 1'b0;
            data_q <= '0;
        end else if (start_i) begin
            need_q <= need_i;
            got_q  <= 1'b0;
            data_q <= '0;
        end else if (go_i && rel_o) begin
            got_q  <= 1'b1;
            data_q <= data_i;
        end
    end
endmodule

// File: rtl/opunit_alu.sv
module opunit_alu
    import opunit_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    logic          vld_q;
    logic [DW-1:0] res_q;
    logic [DW-1:0] res_d;

    assign in_ready  = !vld_q;
    assign out_valid = vld_q;
    assign out_data  = res_q;

    always_comb begin
        unique case (op)
            OP_ADD:  res_d = a + b;
            OP_SUB:  res_d = a - b;
            OP_AND:  res_d = a & b;
            default: res_d = a ^ b;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else if (in_valid && in_ready) begin
            vld_q <= 1'b1;
            res_q <= res_d;
        end else if (vld_q && out_ready) begin
            vld_q <= 1'b0;
        end
    end
endmodule

// File: rtl/opunit_ctrl.sv
module opunit_ctrl
    import opunit_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_i,
    input  logic [1:0]      op_code_i,
    input  logic            inv_a_i,
    input  logic            zero_a_i,
    input  logic [DW-1:0]   imm_i,
    input  logic            imm_ok_i,
    input  logic [NOPS-1:0] rd_mask_i,
    input  logic [NOPS-1:0] rd_go_i,
    input  logic [DW-1:0]   src_a_i,
    input  logic [DW-1:0]   src_b_i,
    input  logic            wr_go_i,
    output logic            busy_o,
    output logic [NOPS-1:0] rd_rel_o,
    output logic            wr_rel_o,
    output logic [DW-1:0]   result_o
);
    logic            busy_q;
    logic            start;
    logic            sent_q;
    op_ctl_t         ctl_q;
    logic [DW-1:0]   imm_q;
    logic [NOPS-1:0] need;
    logic [NOPS-1:0] have;
    logic [DW-1:0]   src_bus  [NOPS];
    logic [DW-1:0]   slot_val [NOPS];
    logic [DW-1:0]   a_eff;
    logic [DW-1:0]   b_eff;
    logic            alu_in_valid;
    logic            alu_in_ready;
    logic            alu_out_valid;
    logic            alu_out_ready;
    logic [DW-1:0]   alu_out_data;
    logic            wr_fire;

    assign start   = issue_i && !busy_q;
    assign need    = operand_need(rd_mask_i, zero_a_i, imm_ok_i);
    assign wr_fire = wr_rel_o && wr_go_i;

    assign src_bus[SRC_A] = src_a_i;
    assign src_bus[SRC_B] = src_b_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ctl_q  <= '0;
            imm_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            ctl_q  <= '{code: alu_op_e'(op_code_i), inv_a: inv_a_i,
                        zero_a: zero_a_i, imm_ok: imm_ok_i};
            imm_q  <= imm_i;
        end else if (wr_fire) begin
            busy_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_slot
        opunit_slot #(.DW(DW)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .start_i (start),
            .need_i  (need[i]),
            .busy_i  (busy_q),
            .go_i    (rd_go_i[i]),
            .data_i  (src_bus[i]),
            .rel_o   (rd_rel_o[i]),
            .have_o  (have[i]),
            .data_o  (slot_val[i])
        );
    end

    always_comb begin
        a_eff = ctl_q.zero_a ? '0 : slot_val[SRC_A];
        if (ctl_q.inv_a) a_eff = ~a_eff;
        b_eff = ctl_q.imm_ok ? imm_q : slot_val[SRC_B];
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            sent_q <= 1'b0;
        end else if (alu_in_valid && alu_in_ready) begin
            sent_q <= 1'b1;
        end
    end

    assign alu_in_valid  = busy_q && (&have) && !sent_q;
    assign alu_out_ready = busy_q && wr_go_i;

    opunit_alu #(.DW(DW)) u_alu (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (alu_in_valid),
        .in_ready  (alu_in_ready),
        .op        (ctl_q.code),
        .a         (a_eff),
        .b         (b_eff),
        .out_valid (alu_out_valid),
        .out_ready (alu_out_ready),
        .out_data  (alu_out_data)
    );

    assign busy_o   = busy_q;
    assign wr_rel_o = busy_q && alu_out_valid;
    assign result_o = alu_out_data;
endmodule

// File: rtl/opunit_ctrl_chk.sv
module opunit_ctrl_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          issue_i,
    input logic [1:0]    rd_go_i,
    input logic          wr_go_i,
    input logic          busy_o,
    input logic [1:0]    rd_rel_o,
    input logic          wr_rel_o,
    input logic [DW-1:0] result_o
);
    // R1: busy only rises after an issue strobe
    a_r1_busy_needs_issue: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(issue_i));

    // R3: an unanswered release stays high
    a_r3_rel_a_holds: assert property (@(posedge clk) disable iff (rst)
        (rd_rel_o[0] && !rd_go_i[0]) |=> rd_rel_o[0]);
    a_r3_rel_b_holds: assert property (@(posedge clk) disable iff (rst)
        (rd_rel_o[1] && !rd_go_i[1]) |=> rd_rel_o[1]);

    // R5: release falls after its go
    a_r5_rel_a_drops: assert property (@(posedge clk) disable iff (rst)
        (rd_rel_o[0] && rd_go_i[0]) |=> !rd_rel_o[0]);
    a_r5_rel_b_drops: assert property (@(posedge clk) disable iff (rst)
        (rd_rel_o[1] && rd_go_i[1]) |=> !rd_rel_o[1]);

    // R8: result held while waiting; busy ends after write-go
    a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
        (wr_rel_o && !wr_go_i) |=> (wr_rel_o && $stable(result_o)));
    a_r8_busy_ends: assert property (@(posedge clk) disable iff (rst)
        (wr_rel_o && wr_go_i) |=> (!busy_o && !wr_rel_o));

    // R9: no read is pending once the result is offered
    a_r9_no_read_after_result: assert property (@(posedge clk) disable iff (rst)
        wr_rel_o |-> (rd_rel_o == 2'b00));

    // R10: busy is held until the write is accepted, whatever issue does
    a_r10_busy_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !(wr_rel_o && wr_go_i)) |=> busy_o);

    // R11: releases only while busy
    a_r11_rel_only_busy: assert property (@(posedge clk) disable iff (rst)
        ((rd_rel_o != 2'b00) || wr_rel_o) |-> busy_o);
endmodule

bind opunit_ctrl opunit_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/opunit_ctrl_test.sv
module opunit_ctrl_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          issue_i;
    logic [1:0]    op_code_i;
    logic          inv_a_i;
    logic          zero_a_i;
    logic [DW-1:0] imm_i;
    logic          imm_ok_i;
    logic [1:0]    rd_mask_i;
    logic [1:0]    rd_go_i;
    logic [DW-1:0] src_a_i;
    logic [DW-1:0] src_b_i;
    logic          wr_go_i;
    logic          busy_o;
    logic [1:0]    rd_rel_o;
    logic          wr_rel_o;
    logic [DW-1:0] result_o;

    int checks   = 0;
    int failures = 0;
    logic [DW-1:0] exp_q [$];

    always #4 clk = ~clk;

    opunit_ctrl #(.DW(DW)) uut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .op_code_i(op_code_i),
        .inv_a_i(inv_a_i), .zero_a_i(zero_a_i), .imm_i(imm_i),
        .imm_ok_i(imm_ok_i), .rd_mask_i(rd_mask_i), .rd_go_i(rd_go_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .wr_go_i(wr_go_i),
        .busy_o(busy_o), .rd_rel_o(rd_rel_o), .wr_rel_o(wr_rel_o),
        .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [DW-1:0] model(
        input logic [1:0] code, input logic inv, input logic zero,
        input logic immok, input logic [DW-1:0] imm, input logic [1:0] mask,
        input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] ea, eb;
        ea = (zero || mask[0]) ? '0 : a;
        if (inv) ea = ~ea;
        eb = immok ? imm : (mask[1] ? '0 : b);
        case (code)
            2'd0:    return ea + eb;
            2'd1:    return ea - eb;
            2'd2:    return ea & eb;
            default: return ea ^ eb;
        endcase
    endfunction

    task automatic idle_inputs();
        issue_i = 0; op_code_i = 0; inv_a_i = 0; zero_a_i = 0;
        imm_i = '0; imm_ok_i = 0; rd_go_i = 0; wr_go_i = 0;
        src_a_i = 16'hDEAD; src_b_i = 16'hBEEF;
    endtask

    // Scoreboard monitor: pops an expected result at every accepted write.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (wr_rel_o && wr_go_i) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 extra result", 32'(result_o), 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(result_o == e, "R12/R7 result", 32'(result_o), 32'(e));
                end
            end
        end
    end

    // Driver: pushes the expected result, issues, answers the handshakes.
    task automatic run_op(input logic [1:0] code, input logic inv,
                          input logic zero, input logic immok,
                          input logic [DW-1:0] imm, input logic [1:0] mask,
                          input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input int da, input int db, input int dw,
                          input bit poke);
        logic [1:0] need;
        int cnt [2];
        int cw;
        int xfer [2];
        bit prev_g [2];
        bit prev_w;
        bit done;
        need = {~mask[1] & ~immok, ~mask[0] & ~zero};
        cnt[0] = da; cnt[1] = db; cw = dw;
        xfer[0] = 0; xfer[1] = 0;
        prev_g[0] = 0; prev_g[1] = 0; prev_w = 0; done = 0;
        exp_q.push_back(model(code, inv, zero, immok, imm, mask, a, b));

        @(negedge clk);
        chk(busy_o == 0, "R1 idle before issue", 32'(busy_o), 0);
        issue_i = 1; op_code_i = code; inv_a_i = inv; zero_a_i = zero;
        imm_ok_i = immok; imm_i = imm; rd_mask_i = mask;
        @(negedge clk);
        // R2: wipe the record fields right after the issue cycle
        issue_i = 0; op_code_i = ~code; inv_a_i = ~inv; zero_a_i = ~zero;
        imm_ok_i = ~immok; imm_i = ~imm;
        chk(busy_o == 1, "R1 busy after issue", 32'(busy_o), 1);
        chk(rd_rel_o == need, "R3/R6 release set", 32'(rd_rel_o), 32'(need));

        for (int cyc = 0; cyc < 60; cyc++) begin
            if (prev_w) begin
                chk(busy_o == 0 && wr_rel_o == 0, "R8 busy drops after write",
                    32'(busy_o), 0);
                done = 1;
                break;
            end
            for (int i = 0; i < 2; i++) begin
                if (prev_g[i])
                    chk(rd_rel_o[i] == 0, "R5 release drops", 32'(rd_rel_o[i]), 0);
            end
            rd_go_i = 0; wr_go_i = 0;
            src_a_i = 16'hDEAD; src_b_i = 16'hBEEF;
            if (poke && cyc == 0) begin
                issue_i = 1; op_code_i = ~code; rd_mask_i = 2'b11;
                zero_a_i = 1; imm_ok_i = 1;
            end else begin
                issue_i = 0; rd_mask_i = mask;
            end
            for (int i = 0; i < 2; i++) begin
                prev_g[i] = 0;
                if (rd_rel_o[i]) begin
                    if (cnt[i] == 0) begin
                        rd_go_i[i] = 1;
                        if (i == 0) src_a_i = a; else src_b_i = b;
                        xfer[i]++;
                        prev_g[i] = 1;
                    end else begin
                        cnt[i]--;
                    end
                end
            end
            if (wr_rel_o) begin
                if (cw == 0) begin
                    wr_go_i = 1;
                    prev_w = 1;
                end else begin
                    cw--;
                end
            end
            @(negedge clk);
        end
        idle_inputs();
        rd_mask_i = 0;
        chk(done, "R8 operation completes", 32'(done), 1);
        chk(xfer[0] == int'(need[0]), "R9 transfers on A", 32'(xfer[0]), 32'(need[0]));
        chk(xfer[1] == int'(need[1]), "R9 transfers on B", 32'(xfer[1]), 32'(need[1]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_sim();
    end

    initial begin
        idle_inputs();
        rd_mask_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk(busy_o == 0, "R11 busy after reset", 32'(busy_o), 0);
        chk(rd_rel_o == 0, "R11 read release after reset", 32'(rd_rel_o), 0);
        chk(wr_rel_o == 0, "R11 write release after reset", 32'(wr_rel_o), 0);

        // R4/R12: same-cycle go on both operands, ADD
        run_op(2'd0, 0, 0, 0, 16'd0, 2'b00, 16'd5, 16'd2, 0, 0, 0, 0);
        // R7: inverted A
        run_op(2'd0, 1, 0, 0, 16'd0, 2'b00, 16'd5, 16'd2, 0, 0, 0, 0);
        // R6/R7: zero-A, only B read
        run_op(2'd0, 0, 1, 0, 16'd0, 2'b00, 16'd5, 16'd2, 0, 1, 0, 0);
        // R6: immediate replaces B
        run_op(2'd0, 0, 0, 1, 16'd9, 2'b00, 16'd5, 16'd2, 1, 0, 0, 0);
        // R6: nothing to read at all
        run_op(2'd0, 0, 1, 1, 16'd3, 2'b00, 16'd5, 16'd2, 0, 0, 1, 0);
        // R9: A first, B stalled; SUB
        run_op(2'd1, 0, 0, 0, 16'd0, 2'b00, 16'd13, 16'd2, 0, 2, 0, 0);
        // R9: B first, A stalled, write delayed; XOR
        run_op(2'd3, 0, 0, 0, 16'd0, 2'b00, 16'd3, 16'd4, 2, 0, 2, 0);
        // R9/R3: both stalled equally; AND
        run_op(2'd2, 0, 0, 0, 16'd0, 2'b00, 16'd21, 16'h0F, 1, 1, 1, 0);
        // R6: both masked, SUB gives 0
        run_op(2'd1, 0, 0, 0, 16'd0, 2'b11, 16'd5, 16'd2, 0, 0, 0, 0);
        // R6: A masked, SUB gives 0 - 2
        run_op(2'd1, 0, 0, 0, 16'd0, 2'b01, 16'd5, 16'd2, 0, 3, 0, 0);
        // R7: zero then invert, plus 1 wraps to 0
        run_op(2'd0, 1, 1, 0, 16'd0, 2'b00, 16'd5, 16'd1, 0, 0, 0, 0);
        // R10: issue poked while busy is ignored
        run_op(2'd0, 0, 0, 0, 16'd0, 2'b00, 16'd5, 16'd2, 2, 2, 1, 1);

        // R11: reset in the middle of an operation
        @(negedge clk);
        issue_i = 1; op_code_i = 2'd0;
        @(negedge clk);
        issue_i = 0;
        chk(rd_rel_o == 2'b11, "R3 release before mid reset", 32'(rd_rel_o), 3);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk(busy_o == 0 && rd_rel_o == 0 && wr_rel_o == 0,
            "R11 mid-operation reset", 32'({busy_o, rd_rel_o, wr_rel_o}), 0);
        @(negedge clk);
        chk(busy_o == 0, "R1 no busy without issue", 32'(busy_o), 0);

        chk(exp_q.size() == 0, "R9 all results seen", 32'(exp_q.size()), 0);
        finish_sim();
    end
endmodule